// File: doc/BRIEF.md
# Run-length capture and replay

The block watches a single-bit serial input and measures the length of each run of consecutive ones. On the first clock where the input drops to zero, it replays that length on its output as an unbroken pulse train of equal length. The output is low at every other time. A small up/down counter holds the measured length. It counts up during the run and counts down during replay, so the same register both measures and meters the pulse train.

Once replay has begun, an internal replay flag locks out the input until the last pulse has been produced. Ones that arrive during replay are neither counted nor added to the pulse train. Runs longer than the counter can represent are clamped to its maximum, which is 15 with the default 4-bit counter. The output is a Mealy output: in the first replay cycle it rises in the same clock in which the input falls.

Top module: `run_replay`

## Requirements
- R1: While rst_ni is low, the count and the replay flag are cleared and z_o is 0. After release, x_i=0 gives z_o=0.
- R2: While not replaying, each clock with x_i=1 raises the count by one, and z_o is 0 during every such clock.
- R3: The count saturates at 2**CNT_W-1 (15 by default). Further ones hold it there, so a run of 20 ones replays as 15 pulses.
- R4: In the first clock with x_i=0 after a run of N>0 ones, z_o is 1 and the count falls by one. The replay flag is set when N is greater than 1.
- R5: While the replay flag is set, x_i is ignored, z_o is 1 and the count falls by one each clock. Ones seen during replay add no pulses.
- R6: The clock in which the count is 1 produces the last pulse and clears the flag. A run of N ones gives exactly min(N,15) consecutive pulses.
- R7: With x_i=0, no replay in progress and a zero count, the block stays idle and z_o is 0.
- R8: A new run may begin in the clock right after the last pulse, and it is counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial input whose runs of ones are measured |
| z_o | output | 1 | Replayed pulse train |

## Verification
On every cycle the assertions check the counter steps: increment, hold at the ceiling, and decrement during replay. They also check the handling of the replay flag at the start and at the end of replay, and the relation between z_o and the internal state. Only the bench scenarios can show that the pulse count equals the measured run length end to end, with a zero-length gap between replay and a new run. They are also the only evidence that ones injected during replay leave no trace after it, and that clamping gives exactly 15 pulses.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // per-cycle action chosen by the controller
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_HOLD  = 2'd2,
    ACT_DRAIN = 2'd3
  } act_e;
endpackage

// File: rtl/rr_counter.sv
module rr_counter
  import rr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  act_e             act_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    unique case (act_i)
      ACT_COUNT: cnt_d = cnt_q + 1'b1;
      ACT_DRAIN: cnt_d = cnt_q - 1'b1;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rr_ctrl.sv
module rr_ctrl
  import rr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             x_i,
  input  logic [CNT_W-1:0] cnt_i,
  output act_e             act_o,
  output logic             rep_o,
  output logic             z_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic rep_q, rep_d;
  act_e act;

  always_comb begin
    if (rep_q)       act = ACT_DRAIN;
    else if (x_i)    act = (cnt_i == CntMax) ? ACT_HOLD : ACT_COUNT;
    else             act = (cnt_i != '0) ? ACT_DRAIN : ACT_IDLE;
  end

  // flag stays up until the final pulse
  assign rep_d = (act == ACT_DRAIN) && (cnt_i != CntOne);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rep_q <= 1'b0;
    else         rep_q <= rep_d;
  end

  assign act_o = act;
  assign rep_o = rep_q;
  assign z_o   = (act == ACT_DRAIN);
endmodule

// File: rtl/run_replay.sv
module run_replay
  import rr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic z_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rep_q;
  act_e             act;

  rr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .x_i    (x_i),
    .cnt_i  (cnt_q),
    .act_o  (act),
    .rep_o  (rep_q),
    .z_o    (z_o)
  );

  rr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .cnt_o  (cnt_q)
  );
endmodule

// File: rtl/run_replay_chk.sv
module run_replay_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             x_i,
  input logic             z_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic             rep_i
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  // R2
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && x_i && cnt_i != CntMax) |=> (cnt_i == $past(cnt_i) + 1'b1));
  // R2
  quiet_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && x_i) |-> !z_o);
  // R3
  ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && x_i && cnt_i == CntMax) |=> (cnt_i == CntMax));
  // R4
  start_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && !x_i && cnt_i > 1) |=> rep_i);
  // R5
  drain_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_i |-> z_o);
  // R5
  drain_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep_i |=> (cnt_i == $past(cnt_i) - 1'b1));
  // R6
  last_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_i && cnt_i == 1) |=> !rep_i);
  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && !x_i && cnt_i == '0) |-> !z_o);
endmodule

bind run_replay run_replay_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .z_o    (z_o),
  .cnt_i  (cnt_q),
  .rep_i  (rep_q)
);

// File: tb/sim_run_replay.sv
`timescale 1ns/1ps
module sim_run_replay;
  localparam int CntMax = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic x = 1'b0;
  logic z;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  run_replay #(.CNT_W(4)) u0 (.clk_i(clk), .rst_ni(rst_ni), .x_i(x), .z_o(z));

  task automatic chk(input logic exp, input string req);
    checks++;
    if (z !== exp) begin
      errors++;
      $display("FAIL %s: z=%b expected %b at %0t", req, z, exp, $time);
    end
  endtask

  // drive at negedge, sample z (Mealy) 1 ns later
  task automatic step(input logic v, input logic exp, input string req);
    @(negedge clk);
    x = v;
    #1;
    chk(exp, req);
  endtask

  task automatic play(input int len);
    int n = (len > CntMax) ? CntMax : len;
    for (int i = 0; i < len; i++) step(1'b1, 1'b0, (i >= CntMax) ? "R3" : "R2");
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b1, (i == 0) ? "R4" : (i == n - 1) ? "R6" : "R5");
    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; chk(1'b0, "R1");
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, 1'b0, "R1");

    // sweep run lengths 0..20 (covers 0, 1, 7, 15, 20)
    for (int len = 0; len <= 20; len++) play(len);

    // lockout: ones during replay are ignored (R5)
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, "R5");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b0, "R7");

    // back-to-back: new run right after last pulse (R8)
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R2");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R5");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, "R8");

    // reset mid-replay (R1)
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R5");
    @(negedge clk); rst_ni = 1'b0; x = 1'b0;
    #1; chk(1'b0, "R1");
    @(negedge clk); rst_ni = 1'b1;
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R7");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule